// File: doc/BRIEF.md
# Out-of-Band Link Initialization Sequencer (Host Side)

This block runs the host end of the out-of-band wake-up handshake on a serial storage link. It drives a single burst-enable line, `txBurst`. While that line is high the PHY sends the ALIGN pattern. While it is low the line sits in electrical idle. On the receive side the PHY gives a per-clock presence flag, `rxSignal`.

The three out-of-band signals use identical bursts and differ only in the idle gap between bursts. For that reason the block tells them apart by counting idle cycles between bursts. It does not look at the data. The long-gap class heard by the host can only be the device's init request, because the host's own reset request travels the other way. The short-gap class is the wake signal.

After reset the host sends a reset request. It waits for the device's init request and answers with a wake signal. It then waits for the device's wake signal and for the line to go quiet, and raises `linkUp`. Missing answers are handled by timeouts, which send the reset request again.

Top module: `oob_link_init`

## Requirements
- R1: After reset the block sends a reset request: exactly NUM_BURSTS (6) bursts of BURST_LEN (27) cycles with `txBurst` high, separated by gaps of RESET_GAP (80) cycles with `txBurst` low.
- R2: When NUM_BURSTS received bursts are separated by long-class gaps while the block waits after its reset request, it answers with a wake signal: 6 bursts of 27 cycles separated by WAKE_GAP (27) idle cycles.
- R3: A received gap is classed as long or short when it lies within ±GAP_TOL (3) cycles of RESET_GAP or WAKE_GAP. A gap of 83 cycles counts as long, and a gap of 84 cycles belongs to neither class.
- R4: If no init request is recognised within INIT_TIMEOUT (1200) cycles after the last burst of the reset request, the reset request is sent again.
- R5: A received gap outside both windows discards the bursts counted so far. For example, 4 good bursts, then one bad gap, then 3 good bursts is not recognised.
- R6: While waiting for the device's wake signal, a sequence with long-class gaps does not count as a wake signal.
- R7: `linkUp` rises only after the device's wake signal has been recognised and `rxSignal` has then stayed low for QUIET_LEN (64) cycles.
- R8: `linkUp` is low during and after reset until the handshake completes. Once high, it stays high until the next reset, whatever is received.
- R9: If no wake signal is recognised within INIT_TIMEOUT cycles after the host's own wake signal ends, the reset request is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxSignal | input | 1 | Per-cycle presence of a received burst (1) or idle line (0) |
| txBurst | output | 1 | Burst enable to the PHY: 1 sends ALIGN, 0 idles the line |
| linkUp | output | 1 | Handshake complete |

## Verification
The hardest condition to reach from the ports is a partly counted received sequence that is broken by one out-of-window gap. Without the discard rule, that sequence would still reach six bursts. The bench sends four bursts, one 50-cycle gap, and three more bursts, so that a counter that kept its value would reach the recognition count. It checks that the host answers with a reset request rather than a wake signal. Both timeout paths are reached by not answering, or by answering with the wrong gap class, and the idle time before the repeated request is measured.

// File: rtl/oob_link_init_pkg.sv
package oob_link_init_pkg;

  typedef enum logic [2:0] {
    ST_RST_KICK, ST_RST_SEND, ST_INIT_WAIT, ST_WAKE_KICK,
    ST_WAKE_SEND, ST_WAKE_WAIT, ST_QUIET_WAIT, ST_LINK_UP
  } seqStateT;

  typedef enum logic [1:0] {PH_IDLE, PH_BURST, PH_GAP} txPhaseT;

  typedef enum logic [1:0] {GAP_NONE, GAP_LONG, GAP_SHORT} gapClassT;

  // control -> datapath strobes
  typedef struct packed {
    logic txStart;   // begin a six-burst sequence
    logic txWake;    // sequence uses the short gap
    logic timerRun;  // timeout counter runs while high, clears while low
  } ctlStrobeT;

  // datapath -> control status
  typedef struct packed {
    logic txDone;
    logic initSeen;
    logic wakeSeen;
    logic lineQuiet;
    logic timeUp;
  } dpStatusT;

endpackage

// File: rtl/oob_link_init_datapath.sv
module oob_link_init_datapath
  import oob_link_init_pkg::*;
#(
  parameter int BURST_LEN    = 27,
  parameter int RESET_GAP    = 80,
  parameter int WAKE_GAP     = 27,
  parameter int GAP_TOL      = 3,
  parameter int NUM_BURSTS   = 6,
  parameter int INIT_TIMEOUT = 1200,
  parameter int QUIET_LEN    = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rxSignal,
  input  ctlStrobeT ctl,
  output logic      txBurst,
  output dpStatusT  sts
);

  localparam int LEN_A   = (BURST_LEN > RESET_GAP) ? BURST_LEN : RESET_GAP;
  localparam int LEN_MAX = (LEN_A > WAKE_GAP) ? LEN_A : WAKE_GAP;
  localparam int CW      = $clog2(LEN_MAX + 1);
  localparam int IW      = $clog2(NUM_BURSTS);
  localparam int IDLE_A  = RESET_GAP + GAP_TOL;
  localparam int IDLE_MAX = ((IDLE_A > QUIET_LEN) ? IDLE_A : QUIET_LEN) + 1;
  localparam int DW      = $clog2(IDLE_MAX + 1);
  localparam int TW      = $clog2(INIT_TIMEOUT + 1);

  // ---------------- transmit burst generator ----------------
  txPhaseT       phase;
  logic [CW-1:0] phCnt;
  logic [IW-1:0] burstIdx;
  logic          wakeSel;
  logic          burstEnd, lastBurst;
  logic [CW-1:0] gapLast;

  assign gapLast   = wakeSel ? CW'(WAKE_GAP - 1) : CW'(RESET_GAP - 1);
  assign lastBurst = (burstIdx == IW'(NUM_BURSTS - 1));
  assign burstEnd  = (phase == PH_BURST) && (phCnt == CW'(BURST_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      phCnt    <= '0;
      burstIdx <= '0;
      wakeSel  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (ctl.txStart) begin
          phase    <= PH_BURST;
          phCnt    <= '0;
          burstIdx <= '0;
          wakeSel  <= ctl.txWake;
        end
        PH_BURST: if (burstEnd) begin
          phCnt <= '0;
          phase <= lastBurst ? PH_IDLE : PH_GAP;
        end else begin
          phCnt <= phCnt + 1'b1;
        end
        PH_GAP: if (phCnt == gapLast) begin
          phCnt    <= '0;
          phase    <= PH_BURST;
          burstIdx <= burstIdx + 1'b1;
        end else begin
          phCnt <= phCnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign txBurst    = (phase == PH_BURST);
  assign sts.txDone = burstEnd && lastBurst;

  // ---------------- receive gap classifier ----------------
  logic          sigR, sigPrev;
  logic [DW-1:0] idleCnt;
  logic          rising;
  gapClassT      gapCls, curCls;
  logic [IW-1:0] matchCnt;
  logic          seenHit;

  function automatic logic inWin(input int cnt, input int nom);
    return (cnt + GAP_TOL >= nom) && (cnt <= nom + GAP_TOL);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sigR    <= 1'b0;
      sigPrev <= 1'b0;
      idleCnt <= DW'(IDLE_MAX);
    end else begin
      sigR    <= rxSignal;
      sigPrev <= sigR;
      if (sigR)                        idleCnt <= '0;
      else if (idleCnt != DW'(IDLE_MAX)) idleCnt <= idleCnt + 1'b1;
    end
  end

  assign rising = sigR && !sigPrev;

  always_comb begin
    if (inWin(int'(idleCnt), RESET_GAP))     gapCls = GAP_LONG;
    else if (inWin(int'(idleCnt), WAKE_GAP)) gapCls = GAP_SHORT;
    else                                     gapCls = GAP_NONE;
  end

  assign seenHit = rising && (gapCls != GAP_NONE) && (gapCls == curCls) &&
                   (matchCnt == IW'(NUM_BURSTS - 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matchCnt <= '0;
      curCls   <= GAP_NONE;
    end else if (rising) begin
      if (gapCls == GAP_NONE || seenHit) begin
        matchCnt <= '0;             // discard partial count, restart
        curCls   <= GAP_NONE;
      end else if (gapCls == curCls) begin
        matchCnt <= matchCnt + 1'b1;
      end else begin
        curCls   <= gapCls;
        matchCnt <= IW'(1);
      end
    end
  end

  assign sts.initSeen  = seenHit && (gapCls == GAP_LONG);
  assign sts.wakeSeen  = seenHit && (gapCls == GAP_SHORT);
  assign sts.lineQuiet = !sigR && (idleCnt >= DW'(QUIET_LEN));

  // ---------------- timeout counter ----------------
  logic [TW-1:0] timer;
  always_ff @(posedge clk) begin
    if (!rst_n || !ctl.timerRun) timer <= '0;
    else if (!sts.timeUp)        timer <= timer + 1'b1;
  end
  assign sts.timeUp = (timer == TW'(INIT_TIMEOUT));

  // R1: a new sequence is only requested when the generator is free
  a_r1_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.txStart |-> (phase == PH_IDLE));

  // R3: a recognised sequence always ends with a burst onset
  a_r3_seen_on_onset: assert property (@(posedge clk) disable iff (!rst_n)
    (sts.initSeen || sts.wakeSeen) |-> (sigR && !sigPrev));

endmodule

// File: rtl/oob_link_init_ctrl.sv
module oob_link_init_ctrl
  import oob_link_init_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  dpStatusT  sts,
  output ctlStrobeT ctl,
  output logic      linkUp
);

  seqStateT state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RST_KICK:   nextState = ST_RST_SEND;
      ST_RST_SEND:   if (sts.txDone) nextState = ST_INIT_WAIT;
      ST_INIT_WAIT:  if (sts.initSeen)    nextState = ST_WAKE_KICK;
                     else if (sts.timeUp) nextState = ST_RST_KICK;
      ST_WAKE_KICK:  nextState = ST_WAKE_SEND;
      ST_WAKE_SEND:  if (sts.txDone) nextState = ST_WAKE_WAIT;
      ST_WAKE_WAIT:  if (sts.wakeSeen)    nextState = ST_QUIET_WAIT;
                     else if (sts.timeUp) nextState = ST_RST_KICK;
      ST_QUIET_WAIT: if (sts.lineQuiet) nextState = ST_LINK_UP;
      ST_LINK_UP:    nextState = ST_LINK_UP;
      default:       nextState = ST_RST_KICK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RST_KICK;
    else        state <= nextState;
  end

  assign ctl.txStart  = (state == ST_RST_KICK) || (state == ST_WAKE_KICK);
  assign ctl.txWake   = (state == ST_WAKE_KICK);
  assign ctl.timerRun = (state == ST_INIT_WAIT) || (state == ST_WAKE_WAIT);
  assign linkUp       = (state == ST_LINK_UP);

  // R2: a recognised init request is answered with a wake sequence
  a_r2_init_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT_WAIT && sts.initSeen) |=> (ctl.txStart && ctl.txWake));

  // R4: timeout without an init request restarts the reset request
  a_r4_timeout_resend: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT_WAIT && sts.timeUp && !sts.initSeen) |=> (ctl.txStart && !ctl.txWake));

  // R7: link comes up only from a quiet line
  a_r7_up_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linkUp) |-> $past(sts.lineQuiet));

  // R8: link indication holds until reset
  a_r8_up_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    linkUp |=> linkUp);

endmodule

// File: rtl/oob_link_init.sv
module oob_link_init
  import oob_link_init_pkg::*;
#(
  parameter int BURST_LEN    = 27,
  parameter int RESET_GAP    = 80,
  parameter int WAKE_GAP     = 27,
  parameter int GAP_TOL      = 3,
  parameter int NUM_BURSTS   = 6,
  parameter int INIT_TIMEOUT = 1200,
  parameter int QUIET_LEN    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxSignal,
  output logic txBurst,
  output logic linkUp
);

  ctlStrobeT ctl;
  dpStatusT  sts;

  oob_link_init_datapath #(
    .BURST_LEN(BURST_LEN), .RESET_GAP(RESET_GAP), .WAKE_GAP(WAKE_GAP),
    .GAP_TOL(GAP_TOL), .NUM_BURSTS(NUM_BURSTS),
    .INIT_TIMEOUT(INIT_TIMEOUT), .QUIET_LEN(QUIET_LEN)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .rxSignal(rxSignal),
    .ctl(ctl), .txBurst(txBurst), .sts(sts)
  );

  oob_link_init_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .sts(sts), .ctl(ctl), .linkUp(linkUp)
  );

endmodule

// File: tb/oob_link_init_tb_top.sv
`timescale 1ns/1ps
module oob_link_init_tb_top;

  localparam int BL = 27, LG = 80, SG = 27, TO = 1200, QL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxSignal = 1'b0;
  logic txBurst, linkUp;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  oob_link_init dut_i (
    .clk(clk), .rst_n(rst_n), .rxSignal(rxSignal),
    .txBurst(txBurst), .linkUp(linkUp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    rxSignal = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sendSeq(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      rxSignal = 1'b1;
      repeat (BL) @(negedge clk);
      rxSignal = 1'b0;
      if (i < n - 1) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic captureTx(output int waitCyc, output int minHi, output int maxHi,
                           output int minLo, output int maxLo);
    int hi, lo;
    waitCyc = 0; minHi = 99999; maxHi = 0; minLo = 99999; maxLo = 0;
    do begin
      @(negedge clk);
      waitCyc++;
    end while (!txBurst && waitCyc < 5000);
    for (int b = 0; b < 6; b++) begin
      hi = 0;
      while (txBurst && hi < 5000) begin hi++; @(negedge clk); end
      if (hi < minHi) minHi = hi;
      if (hi > maxHi) maxHi = hi;
      if (b < 5) begin
        lo = 0;
        while (!txBurst && lo < 5000) begin lo++; @(negedge clk); end
        if (lo < minLo) minLo = lo;
        if (lo > maxLo) maxLo = lo;
      end
    end
  endtask

  task automatic expectShape(input string req, input string what, input int gap,
                             input int minHi, input int maxHi, input int minLo, input int maxLo);
    check(minHi == BL && maxHi == BL, req, {what, " burst length"}, maxHi, BL);
    check(minLo == gap && maxLo == gap, req, {what, " gap length"}, maxLo, gap);
  endtask

  // reset state
  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(linkUp == 1'b0, "R8", "linkUp in reset", linkUp, 0);
    check(txBurst == 1'b0, "R1", "txBurst in reset", txBurst, 0);
    rst_n = 1'b1;
  endtask

  // R1 and R4: reset request shape and resend on silence
  task automatic t_reset_and_timeout();
    int w, a, b, c, d;
    doReset();
    captureTx(w, a, b, c, d);
    expectShape("R1", "first reset request", LG, a, b, c, d);
    captureTx(w, a, b, c, d);
    check(w >= TO - 5 && w <= TO + 8, "R4", "idle before resend", w, TO);
    expectShape("R4", "resent reset request", LG, a, b, c, d);
  endtask

  // R2, R7, R8: full handshake
  task automatic t_handshake();
    int w, a, b, c, d;
    doReset();
    captureTx(w, a, b, c, d);
    fork
      sendSeq(6, LG);
      captureTx(w, a, b, c, d);
    join
    expectShape("R2", "wake answer", SG, a, b, c, d);
    check(linkUp == 1'b0, "R7", "linkUp before device wake", linkUp, 0);
    sendSeq(6, SG - 3);   // lower edge of the short window (R3)
    repeat (QL - 14) @(negedge clk);
    check(linkUp == 1'b0, "R7", "linkUp before quiet time", linkUp, 0);
    repeat (30) @(negedge clk);
    check(linkUp == 1'b1, "R7", "linkUp after quiet time", linkUp, 1);
    sendSeq(6, LG);
    sendSeq(3, 50);
    repeat (100) @(negedge clk);
    check(linkUp == 1'b1, "R8", "linkUp held after later bursts", linkUp, 1);
  endtask

  // R3: tolerance window edge
  task automatic t_tolerance();
    int w, a, b, c, d;
    doReset();
    captureTx(w, a, b, c, d);
    fork
      sendSeq(6, LG + 3);
      captureTx(w, a, b, c, d);
    join
    expectShape("R3", "answer to gap 83", SG, a, b, c, d);
    doReset();
    captureTx(w, a, b, c, d);
    fork
      sendSeq(6, LG + 4);
      captureTx(w, a, b, c, d);
    join
    expectShape("R3", "answer to gap 84", LG, a, b, c, d);
  endtask

  // R5: a bad gap discards the partial count
  task automatic t_discard();
    int w, a, b, c, d;
    doReset();
    captureTx(w, a, b, c, d);
    fork
      begin
        sendSeq(4, LG);
        repeat (50) @(negedge clk);
        sendSeq(3, LG);
      end
      captureTx(w, a, b, c, d);
    join
    expectShape("R5", "answer after broken sequence", LG, a, b, c, d);
  endtask

  // R6 and R9: wrong class while waiting for wake, then timeout
  task automatic t_wrong_wake();
    int w, a, b, c, d;
    doReset();
    captureTx(w, a, b, c, d);
    fork
      sendSeq(6, LG);
      captureTx(w, a, b, c, d);
    join
    expectShape("R2", "wake answer", SG, a, b, c, d);
    fork
      sendSeq(6, LG);
      captureTx(w, a, b, c, d);
    join
    check(linkUp == 1'b0, "R6", "linkUp after long-gap sequence", linkUp, 0);
    check(w >= TO - 5 && w <= TO + 8, "R9", "idle before resend", w, TO);
    expectShape("R9", "reset request after wake timeout", LG, a, b, c, d);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset_state();
    t_reset_and_timeout();
    t_handshake();
    t_tolerance();
    t_discard();
    t_wrong_wake();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule